// File: doc/BRIEF.md
# Banked Level Interrupt Register File

This block is the register-side front end of an interrupt controller with 96 level-sensitive lines, grouped as three banks of 32. The block samples the raw request lines every cycle. It keeps a set of software-raised interrupt bits per bank and presents each line as pending while either its input or its software bit is set. Per bank, a mask can be written whole or changed bit by bit through separate set and clear words. Each line also has a configuration word that holds a priority and a class, where class 0 is the normal interrupt path and class 1 is the fast path.

The arbitration itself lives outside. It receives the pending set, the masks, the classes, the priorities and a global enable from this block. It returns its current winning line numbers, which software reads back here. Software uses the control register to tell the arbiter that it may start a new round for either path. The sysconfig register holds an autoidle bit and can trigger a soft reset of all register state.

The bus is a simple 32-bit word bus. A request is accepted in one cycle and answered in the next with read data and an error flag.

Top module: `intc_regfile`

## Requirements
- R1: After reset every bank mask reads 0xFFFFFFFF, software bits read 0, every line configuration word reads 0, the control register reads 0, global_en_o is 1 and line_mask_o is all ones.
- R2: Address 0x000 reads 0x21, 0x014 reads 1, 0x040 returns irq_vec_i zero-extended and 0x044 returns fiq_vec_i zero-extended; writes to these have no effect.
- R3: Bank b occupies 0x080+0x20*b. Offset +0x00 reads the input lines as sampled at the previous clock edge, and pending_o equals the sampled inputs OR the software bits.
- R4: Offset +0x04 writes and reads the mask. A write to +0x08 clears only the mask bits written as 1, and a write to +0x0C sets only the mask bits written as 1. Both of these offsets read 0.
- R5: A write to +0x10 ORs the value into the software bits, which then also appear in pending. Reading +0x10 returns the software bits. A write to +0x14 removes the written bits from the software bits, after which pending is recomputed from the inputs and the remaining software bits. Reading +0x14 returns 0.
- R6: Offset +0x18 reads pending & ~mask & ~class, and offset +0x1C reads pending & ~mask & class.
- R7: The control register is at 0x048. Bit 2 is the global mask: it is readable, and while it is 1 global_en_o is 0. Writing bit 0 gives a one-cycle pulse on new_irq_agr_o and writing bit 1 gives a one-cycle pulse on new_fiq_agr_o. Bits 1 and 0 read 0.
- R8: The sysconfig register is at 0x010. Bit 0 is autoidle, readable and driven on autoidle_o. Writing bit 1 returns all register state to the values of R1, including autoidle, the idle bits and the global mask. The idle register at 0x050 holds two read/write bits [1:0], driven on idle_mode_o.
- R9: Line n is configured at 0x100+4*n for n below 96. Bits [7:2] hold the priority and bit 0 holds the class, and all other bits read 0. The fields drive line_prio_o[6n+:6] and line_class_o[n].
- R10: An access to an unmapped address, to a bank index of 3 or above, or to an address whose bits [1:0] are not 0 returns rdata 0 with bus_err 1 and changes no state.
- R11: Every request cycle is answered in the next cycle by bus_rvalid, and a read issued right after a write sees that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 96 | Level interrupt request lines |
| irq_vec_i | input | 7 | Current normal-path winner from the arbiter |
| fiq_vec_i | input | 7 | Current fast-path winner from the arbiter |
| bus_req | input | 1 | Bus request valid |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rvalid | output | 1 | Response valid, one cycle after request |
| bus_rdata | output | 32 | Read data |
| bus_err | output | 1 | Error response |
| line_mask_o | output | 96 | Per-line mask |
| line_class_o | output | 96 | Per-line class (1 = fast path) |
| line_prio_o | output | 576 | Per-line 6-bit priority, line n at [6n+:6] |
| pending_o | output | 96 | Inputs OR software bits |
| global_en_o | output | 1 | Global output enable |
| autoidle_o | output | 1 | Autoidle bit |
| idle_mode_o | output | 2 | Idle register bits |
| new_irq_agr_o | output | 1 | New normal-path round pulse |
| new_fiq_agr_o | output | 1 | New fast-path round pulse |

## Verification
Some behaviours are checked by assertions on every cycle. These are the one-cycle response timing and the zero data on error responses. They also cover the bitwise effect of mask set and clear and of software clear on the stored bits, and the stored priority after a line write. The agreement pulses and the return of the global registers after a soft reset are checked the same way. Only the directed scenarios show address decoding and register layout. The same holds for the two pending views under mixed classes and masks, the recomputation of pending once software bits are removed, and the absence of side effects from erroneous accesses.

// File: rtl/intc_pkg.sv
package intc_pkg;
    localparam int unsigned DATA_W = 32;
    localparam int unsigned ADDR_W = 12;

    typedef enum logic [2:0] {
        BK_RAW  = 3'd0,
        BK_MASK = 3'd1,
        BK_MCLR = 3'd2,
        BK_MSET = 3'd3,
        BK_SSET = 3'd4,
        BK_SCLR = 3'd5,
        BK_PIRQ = 3'd6,
        BK_PFIQ = 3'd7
    } bank_reg_e;

    typedef enum logic [2:0] {
        G_NONE    = 3'd0,
        G_REV     = 3'd1,
        G_SYSCFG  = 3'd2,
        G_SYSSTAT = 3'd3,
        G_VIRQ    = 3'd4,
        G_VFIQ    = 3'd5,
        G_CTRL    = 3'd6,
        G_IDLE    = 3'd7
    } glob_reg_e;

    localparam logic [ADDR_W-1:0] A_REV     = 12'h000;
    localparam logic [ADDR_W-1:0] A_SYSCFG  = 12'h010;
    localparam logic [ADDR_W-1:0] A_SYSSTAT = 12'h014;
    localparam logic [ADDR_W-1:0] A_VIRQ    = 12'h040;
    localparam logic [ADDR_W-1:0] A_VFIQ    = 12'h044;
    localparam logic [ADDR_W-1:0] A_CTRL    = 12'h048;
    localparam logic [ADDR_W-1:0] A_IDLE    = 12'h050;
    localparam logic [ADDR_W-3:0] W_LINE_BASE = 10'h040;
    localparam logic [7:0]        REV_VALUE = 8'h21;

    typedef struct packed {
        logic              rvalid;
        logic              err;
        logic [DATA_W-1:0] rdata;
    } rsp_t;
endpackage

// File: rtl/intc_bank.sv
module intc_bank
    import intc_pkg::*;
#(
    parameter int LINES = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic [LINES-1:0]  raw_i,
    input  logic              wr_en,
    input  bank_reg_e         reg_sel,
    input  logic [LINES-1:0]  wdata,
    input  logic [LINES-1:0]  cls_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic [LINES-1:0]  mask_o,
    output logic [LINES-1:0]  pend_o
);
    typedef struct packed {
        logic [LINES-1:0] raw;
        logic [LINES-1:0] mask;
        logic [LINES-1:0] swi;
    } bank_st_t;

    bank_st_t st_d, st_q;
    logic [LINES-1:0] pend;

    assign pend   = st_q.raw | st_q.swi;
    assign pend_o = pend;
    assign mask_o = st_q.mask;

    always_comb begin
        st_d     = st_q;
        st_d.raw = raw_i;
        if (wr_en) begin
            case (reg_sel)
                BK_MASK: st_d.mask = wdata;
                BK_MCLR: st_d.mask = st_q.mask & ~wdata;
                BK_MSET: st_d.mask = st_q.mask | wdata;
                BK_SSET: st_d.swi  = st_q.swi | wdata;
                BK_SCLR: st_d.swi  = st_q.swi & ~wdata;
                default: ;
            endcase
        end
        if (soft_rst) begin
            st_d.mask = '1;
            st_d.swi  = '0;
        end
    end

    always_comb begin
        rdata_o = '0;
        case (reg_sel)
            BK_RAW:  rdata_o[LINES-1:0] = st_q.raw;
            BK_MASK: rdata_o[LINES-1:0] = st_q.mask;
            BK_SSET: rdata_o[LINES-1:0] = st_q.swi;
            BK_PIRQ: rdata_o[LINES-1:0] = pend & ~st_q.mask & ~cls_i;
            BK_PFIQ: rdata_o[LINES-1:0] = pend & ~st_q.mask & cls_i;
            default: rdata_o = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.raw  <= '0;
            st_q.mask <= '1;
            st_q.swi  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R4
    mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_sel == BK_MSET) |=> ((st_q.mask & $past(wdata)) == $past(wdata)));

    // R4
    mask_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_sel == BK_MCLR) |=> ((st_q.mask & $past(wdata)) == '0));

    // R5
    swi_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_sel == BK_SCLR) |=> ((st_q.swi & $past(wdata)) == '0));

    // R3
    pend_has_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend_o & $past(raw_i)) == $past(raw_i)));
endmodule

// File: rtl/intc_line_cfg.sv
module intc_line_cfg
    import intc_pkg::*;
#(
    parameter int NLINES = 96,
    parameter int PRIO_W = 6,
    parameter int IDX_W  = $clog2(NLINES)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     soft_rst,
    input  logic                     wr_en,
    input  logic [IDX_W-1:0]         idx,
    input  logic [PRIO_W-1:0]        wr_prio,
    input  logic                     wr_cls,
    output logic [DATA_W-1:0]        rdata_o,
    output logic [NLINES*PRIO_W-1:0] prio_o,
    output logic [NLINES-1:0]        cls_o
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NLINES - 1);

    typedef struct packed {
        logic [NLINES-1:0][PRIO_W-1:0] prio;
        logic [NLINES-1:0]             cls;
    } line_st_t;

    line_st_t st_d, st_q;
    logic     idx_ok;

    assign idx_ok = (idx <= LAST_IDX);
    assign prio_o = st_q.prio;
    assign cls_o  = st_q.cls;

    always_comb begin
        st_d = st_q;
        if (wr_en && idx_ok) begin
            st_d.prio[idx] = wr_prio;
            st_d.cls[idx]  = wr_cls;
        end
        if (soft_rst) begin
            st_d = '0;
        end
    end

    always_comb begin
        rdata_o = '0;
        if (idx_ok) begin
            rdata_o[PRIO_W+1:2] = st_q.prio[idx];
            rdata_o[0]          = st_q.cls[idx];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R9
    line_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && idx_ok) |=> (st_q.prio[$past(idx)] == $past(wr_prio)
                               && st_q.cls[$past(idx)] == $past(wr_cls)));
endmodule

// File: rtl/intc_glob.sv
module intc_glob
    import intc_pkg::*;
#(
    parameter int VEC_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  glob_reg_e         sel,
    input  logic [2:0]        wdata,
    input  logic [VEC_W-1:0]  irq_vec_i,
    input  logic [VEC_W-1:0]  fiq_vec_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              soft_rst_o,
    output logic              global_en_o,
    output logic              autoidle_o,
    output logic [1:0]        idle_o,
    output logic              new_irq_agr_o,
    output logic              new_fiq_agr_o
);
    typedef struct packed {
        logic       autoidle;
        logic [1:0] idle;
        logic       gmask;
        logic       agr_irq;
        logic       agr_fiq;
    } glob_st_t;

    glob_st_t st_d, st_q;

    assign soft_rst_o    = wr_en && (sel == G_SYSCFG) && wdata[1];
    assign global_en_o   = ~st_q.gmask;
    assign autoidle_o    = st_q.autoidle;
    assign idle_o        = st_q.idle;
    assign new_irq_agr_o = st_q.agr_irq;
    assign new_fiq_agr_o = st_q.agr_fiq;

    always_comb begin
        st_d         = st_q;
        st_d.agr_irq = 1'b0;
        st_d.agr_fiq = 1'b0;
        if (wr_en) begin
            case (sel)
                G_SYSCFG: st_d.autoidle = wdata[0];
                G_CTRL: begin
                    st_d.gmask   = wdata[2];
                    st_d.agr_fiq = wdata[1];
                    st_d.agr_irq = wdata[0];
                end
                G_IDLE:   st_d.idle = wdata[1:0];
                default: ;
            endcase
        end
        if (soft_rst_o) begin
            st_d = '0;
        end
    end

    always_comb begin
        rdata_o = '0;
        case (sel)
            G_REV:     rdata_o[7:0]       = REV_VALUE;
            G_SYSCFG:  rdata_o[0]         = st_q.autoidle;
            G_SYSSTAT: rdata_o[0]         = 1'b1;
            G_VIRQ:    rdata_o[VEC_W-1:0] = irq_vec_i;
            G_VFIQ:    rdata_o[VEC_W-1:0] = fiq_vec_i;
            G_CTRL:    rdata_o[2]         = st_q.gmask;
            G_IDLE:    rdata_o[1:0]       = st_q.idle;
            default:   rdata_o = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R8
    soft_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_o |=> (global_en_o && !autoidle_o && idle_o == 2'b00));

    // R7
    agr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == G_CTRL) |=> (new_irq_agr_o == $past(wdata[0])
                                      && new_fiq_agr_o == $past(wdata[1])));

    // R7
    agr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && sel == G_CTRL) |=> (!new_irq_agr_o && !new_fiq_agr_o));
endmodule

// File: rtl/intc_regfile.sv
module intc_regfile
    import intc_pkg::*;
#(
    parameter int NBANKS     = 3,
    parameter int BANK_LINES = 32,
    parameter int PRIO_W     = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NBANKS*BANK_LINES-1:0] irq_in,
    input  logic [$clog2(NBANKS*BANK_LINES)-1:0] irq_vec_i,
    input  logic [$clog2(NBANKS*BANK_LINES)-1:0] fiq_vec_i,
    input  logic                     bus_req,
    input  logic                     bus_we,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [DATA_W-1:0]        bus_wdata,
    output logic                     bus_rvalid,
    output logic [DATA_W-1:0]        bus_rdata,
    output logic                     bus_err,
    output logic [NBANKS*BANK_LINES-1:0] line_mask_o,
    output logic [NBANKS*BANK_LINES-1:0] line_class_o,
    output logic [NBANKS*BANK_LINES*PRIO_W-1:0] line_prio_o,
    output logic [NBANKS*BANK_LINES-1:0] pending_o,
    output logic                     global_en_o,
    output logic                     autoidle_o,
    output logic [1:0]               idle_mode_o,
    output logic                     new_irq_agr_o,
    output logic                     new_fiq_agr_o
);
    localparam int NLINES = NBANKS * BANK_LINES;
    localparam int VEC_W  = $clog2(NLINES);
    localparam int LIDX_W = $clog2(NLINES);
    localparam logic [1:0]        LAST_BANK = 2'(NBANKS - 1);
    localparam logic [ADDR_W-3:0] LINE_CNT  = (ADDR_W-2)'(NLINES);

    // address decode
    logic              aligned;
    logic              hit_bank, hit_line, hit_glob;
    logic [1:0]        bank_idx;
    bank_reg_e         bank_reg;
    logic [ADDR_W-3:0] line_word;
    logic [LIDX_W-1:0] line_idx;
    glob_reg_e         glob_sel;
    logic              wr_any;

    assign aligned   = (bus_addr[1:0] == 2'b00);
    assign bank_idx  = bus_addr[6:5];
    assign bank_reg  = bank_reg_e'(bus_addr[4:2]);
    assign line_word = bus_addr[ADDR_W-1:2] - W_LINE_BASE;
    assign line_idx  = line_word[LIDX_W-1:0];
    assign wr_any    = bus_req && bus_we;

    always_comb begin
        hit_bank = 1'b0;
        hit_line = 1'b0;
        glob_sel = G_NONE;
        if (aligned) begin
            if (bus_addr[ADDR_W-1:7] == 5'b00001) begin
                hit_bank = (bank_idx <= LAST_BANK);
            end else if (bus_addr[ADDR_W-1:8] != 4'h0) begin
                hit_line = (line_word < LINE_CNT);
            end else begin
                case (bus_addr)
                    A_REV:     glob_sel = G_REV;
                    A_SYSCFG:  glob_sel = G_SYSCFG;
                    A_SYSSTAT: glob_sel = G_SYSSTAT;
                    A_VIRQ:    glob_sel = G_VIRQ;
                    A_VFIQ:    glob_sel = G_VFIQ;
                    A_CTRL:    glob_sel = G_CTRL;
                    A_IDLE:    glob_sel = G_IDLE;
                    default:   glob_sel = G_NONE;
                endcase
            end
        end
    end
    assign hit_glob = (glob_sel != G_NONE);

    // global registers
    logic [DATA_W-1:0] glob_rd;
    logic              soft_rst;

    intc_glob #(.VEC_W(VEC_W)) u_glob (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en         (wr_any && hit_glob),
        .sel           (glob_sel),
        .wdata         (bus_wdata[2:0]),
        .irq_vec_i     (irq_vec_i),
        .fiq_vec_i     (fiq_vec_i),
        .rdata_o       (glob_rd),
        .soft_rst_o    (soft_rst),
        .global_en_o   (global_en_o),
        .autoidle_o    (autoidle_o),
        .idle_o        (idle_mode_o),
        .new_irq_agr_o (new_irq_agr_o),
        .new_fiq_agr_o (new_fiq_agr_o)
    );

    // per-line configuration
    logic [DATA_W-1:0] line_rd;

    intc_line_cfg #(.NLINES(NLINES), .PRIO_W(PRIO_W), .IDX_W(LIDX_W)) u_line (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .wr_en    (wr_any && hit_line),
        .idx      (line_idx),
        .wr_prio  (bus_wdata[PRIO_W+1:2]),
        .wr_cls   (bus_wdata[0]),
        .rdata_o  (line_rd),
        .prio_o   (line_prio_o),
        .cls_o    (line_class_o)
    );

    // banks
    logic [DATA_W-1:0] bank_rd [NBANKS];

    for (genvar b = 0; b < NBANKS; b++) begin : g_bank
        intc_bank #(.LINES(BANK_LINES)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .soft_rst (soft_rst),
            .raw_i    (irq_in[b*BANK_LINES +: BANK_LINES]),
            .wr_en    (wr_any && hit_bank && bank_idx == 2'(b)),
            .reg_sel  (bank_reg),
            .wdata    (bus_wdata[BANK_LINES-1:0]),
            .cls_i    (line_class_o[b*BANK_LINES +: BANK_LINES]),
            .rdata_o  (bank_rd[b]),
            .mask_o   (line_mask_o[b*BANK_LINES +: BANK_LINES]),
            .pend_o   (pending_o[b*BANK_LINES +: BANK_LINES])
        );
    end

    // response
    rsp_t rsp_d, rsp_q;

    always_comb begin
        rsp_d        = '0;
        rsp_d.rvalid = bus_req;
        rsp_d.err    = bus_req && !(hit_bank || hit_line || hit_glob);
        if (bus_req && !bus_we) begin
            if (hit_bank) begin
                for (int b = 0; b < NBANKS; b++) begin
                    if (bank_idx == 2'(b)) rsp_d.rdata = bank_rd[b];
                end
            end else if (hit_line) begin
                rsp_d.rdata = line_rd;
            end else if (hit_glob) begin
                rsp_d.rdata = glob_rd;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign bus_rvalid = rsp_q.rvalid;
    assign bus_err    = rsp_q.err;
    assign bus_rdata  = rsp_q.rdata;

    // R11
    rsp_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |=> bus_rvalid);

    // R11
    rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_req |=> !bus_rvalid);

    // R10
    err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rvalid && bus_err) |-> (bus_rdata == '0));
endmodule

// File: tb/intc_regfile_tb.sv
module intc_regfile_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [95:0] irq_in = '0;
    logic [6:0]  irq_vec_i = '0;
    logic [6:0]  fiq_vec_i = '0;
    logic        bus_req = 1'b0;
    logic        bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rvalid, bus_err;
    logic [31:0] bus_rdata;
    logic [95:0] line_mask_o, line_class_o, pending_o;
    logic [575:0] line_prio_o;
    logic        global_en_o, autoidle_o, new_irq_agr_o, new_fiq_agr_o;
    logic [1:0]  idle_mode_o;

    int  checks = 0;
    int  fails  = 0;
    bit  done   = 1'b0;
    logic last_rvalid;
    logic last_err;

    always #(CLK_PERIOD/2) clk = ~clk;

    intc_regfile u_dut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
        .irq_vec_i(irq_vec_i), .fiq_vec_i(fiq_vec_i),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata), .bus_err(bus_err),
        .line_mask_o(line_mask_o), .line_class_o(line_class_o), .line_prio_o(line_prio_o),
        .pending_o(pending_o), .global_en_o(global_en_o), .autoidle_o(autoidle_o),
        .idle_mode_o(idle_mode_o), .new_irq_agr_o(new_irq_agr_o), .new_fiq_agr_o(new_fiq_agr_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
        last_rvalid = bus_rvalid;
        last_err = bus_err;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_req = 1'b0;
        d = bus_rdata;
        last_rvalid = bus_rvalid;
        last_err = bus_err;
    endtask

    task automatic read_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] d;
        bus_read(a, d);
        check(req, d, exp);
    endtask

    task automatic t_reset();
        check("R1 global_en", 32'(global_en_o), 32'd1);
        check("R1 line_mask", 32'(&line_mask_o), 32'd1);
        read_chk("R1 bank0 mask", 12'h084, 32'hFFFF_FFFF);
        read_chk("R1 bank2 swi", 12'h0D0, 32'h0);
        read_chk("R1 line5 cfg", 12'h114, 32'h0);
        read_chk("R1 control", 12'h048, 32'h0);
    endtask

    task automatic t_ident();
        irq_vec_i = 7'd45;
        fiq_vec_i = 7'd3;
        read_chk("R2 revision", 12'h000, 32'h21);
        check("R11 rvalid", 32'(last_rvalid), 32'd1);
        @(negedge clk);
        check("R11 rvalid idle", 32'(bus_rvalid), 32'd0);
        read_chk("R2 sysstatus", 12'h014, 32'h1);
        read_chk("R2 irq vector", 12'h040, 32'd45);
        read_chk("R2 fiq vector", 12'h044, 32'd3);
        bus_write(12'h000, 32'h0);
        read_chk("R2 revision after write", 12'h000, 32'h21);
    endtask

    task automatic t_raw();
        irq_in[33] = 1'b1;
        irq_in[95] = 1'b1;
        read_chk("R3 bank1 raw", 12'h0A0, 32'h0000_0002);
        read_chk("R3 bank2 raw", 12'h0C0, 32'h8000_0000);
        check("R3 pending 33", 32'(pending_o[33]), 32'd1);
        check("R3 pending 95", 32'(pending_o[95]), 32'd1);
        irq_in[33] = 1'b0;
        irq_in[95] = 1'b0;
        read_chk("R3 bank1 raw drop", 12'h0A0, 32'h0);
        check("R3 pending drop", 32'(|pending_o), 32'd0);
    endtask

    task automatic t_mask();
        bus_write(12'h084, 32'hF0F0_0000);
        read_chk("R4 mask write", 12'h084, 32'hF0F0_0000);
        check("R4 line_mask", line_mask_o[31:0], 32'hF0F0_0000);
        bus_write(12'h088, 32'h00F0_0000);
        read_chk("R4 mask clear", 12'h084, 32'hF000_0000);
        bus_write(12'h08C, 32'h0000_000F);
        read_chk("R4 mask set", 12'h084, 32'hF000_000F);
        read_chk("R4 clear reads 0", 12'h088, 32'h0);
        read_chk("R4 set reads 0", 12'h08C, 32'h0);
    endtask

    task automatic t_swi();
        bus_write(12'h0D0, 32'h0000_0300);
        read_chk("R5 swi set", 12'h0D0, 32'h0000_0300);
        check("R5 pending swi", 32'(pending_o[73:72]), 32'd3);
        bus_write(12'h0D4, 32'h0000_0100);
        read_chk("R5 swi clear", 12'h0D0, 32'h0000_0200);
        check("R5 pending recompute", 32'(pending_o[73:72]), 32'd2);
        read_chk("R5 clear reads 0", 12'h0D4, 32'h0);
    endtask

    task automatic t_views();
        bus_write(12'h088, 32'hFFFF_FFFF);
        bus_write(12'h108, 32'h0000_0001);
        bus_write(12'h090, 32'h0000_0006);
        irq_in[3] = 1'b1;
        read_chk("R6 pending irq", 12'h098, 32'h0000_000A);
        read_chk("R6 pending fiq", 12'h09C, 32'h0000_0004);
        bus_write(12'h08C, 32'h0000_0008);
        read_chk("R6 pending irq masked", 12'h098, 32'h0000_0002);
        irq_in[3] = 1'b0;
    endtask

    task automatic t_ctrl();
        bus_write(12'h048, 32'h4);
        check("R7 global_en off", 32'(global_en_o), 32'd0);
        read_chk("R7 control gm", 12'h048, 32'h4);
        bus_write(12'h048, 32'h3);
        check("R7 irq pulse", 32'(new_irq_agr_o), 32'd1);
        check("R7 fiq pulse", 32'(new_fiq_agr_o), 32'd1);
        check("R7 global_en on", 32'(global_en_o), 32'd1);
        @(negedge clk);
        check("R7 pulse ends", 32'({new_irq_agr_o, new_fiq_agr_o}), 32'd0);
        read_chk("R7 control bits read 0", 12'h048, 32'h0);
    endtask

    task automatic t_line();
        bus_write(12'h218, 32'hFFFF_FFFF);
        read_chk("R9 line70 cfg", 12'h218, 32'h0000_00FD);
        check("R9 line70 prio", 32'(line_prio_o[70*6 +: 6]), 32'd63);
        check("R9 line70 class", 32'(line_class_o[70]), 32'd1);
        bus_write(12'h27C, 32'h0000_0029);
        read_chk("R9 line95 cfg", 12'h27C, 32'h0000_0029);
        check("R9 line95 prio", 32'(line_prio_o[95*6 +: 6]), 32'd10);
    endtask

    task automatic t_err();
        read_chk("R10 bank3 data", 12'h0E0, 32'h0);
        check("R10 bank3 err", 32'(last_err), 32'd1);
        bus_write(12'h0E4, 32'h0);
        check("R10 bank3 write err", 32'(last_err), 32'd1);
        read_chk("R10 bank0 mask kept", 12'h084, 32'h0000_0008);
        read_chk("R10 bank1 mask kept", 12'h0A4, 32'hFFFF_FFFF);
        read_chk("R10 bank2 mask kept", 12'h0C4, 32'hFFFF_FFFF);
        read_chk("R10 line96", 12'h280, 32'h0);
        check("R10 line96 err", 32'(last_err), 32'd1);
        read_chk("R10 unmapped", 12'h04C, 32'h0);
        check("R10 unmapped err", 32'(last_err), 32'd1);
        read_chk("R10 misaligned", 12'h086, 32'h0);
        check("R10 misaligned err", 32'(last_err), 32'd1);
        read_chk("R10 good access", 12'h014, 32'h1);
        check("R10 no err", 32'(last_err), 32'd0);
    endtask

    task automatic t_sysconfig();
        bus_write(12'h010, 32'h1);
        read_chk("R8 autoidle", 12'h010, 32'h1);
        check("R8 autoidle_o", 32'(autoidle_o), 32'd1);
        bus_write(12'h050, 32'hFFFF_FFFE);
        read_chk("R8 idle", 12'h050, 32'h2);
        check("R8 idle_mode_o", 32'(idle_mode_o), 32'd2);
        bus_write(12'h048, 32'h4);
        bus_write(12'h0B0, 32'h0000_0010);
        bus_write(12'h010, 32'h2);
        read_chk("R8 sysconfig after reset", 12'h010, 32'h0);
        read_chk("R8 bank0 mask reset", 12'h084, 32'hFFFF_FFFF);
        read_chk("R8 bank1 swi reset", 12'h0B0, 32'h0);
        read_chk("R8 line70 reset", 12'h218, 32'h0);
        read_chk("R8 control reset", 12'h048, 32'h0);
        read_chk("R8 idle reset", 12'h050, 32'h0);
        check("R8 global_en", 32'(global_en_o), 32'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ident();
        t_raw();
        t_mask();
        t_swi();
        t_views();
        t_ctrl();
        t_line();
        t_err();
        t_sysconfig();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule